// File: doc/BRIEF.md
# Logical and Shift Execution Stage

This block is the execute step for the bitwise, shift and simple add operations of a 32-bit load/store style integer pipeline. Each cycle it takes one instruction word and the two source register values that the register file has already read for it. It decodes the register-form or immediate-form fields and computes the result. One clock edge later it presents the result, the index of the register to write and a write strobe. The register file, memory and branch logic sit outside this block.

Register-form instructions carry a zero major opcode. A function code selects add, AND, OR, XOR or one of three shifts by a constant amount taken from the instruction. Immediate-form instructions select their operation with the major opcode and write the register named by the second source field. The logical immediates are widened with zeros. The add immediate is widened with its sign bit. Load-upper places the 16-bit constant in the upper half of the result. Encodings the block does not recognise, and writes aimed at register 0, leave the write strobe low.

Top module: `bitop_exec_stage`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `result_o`, `wr_idx_o` and `wr_en_o` are all zero.
- R2: The outputs reflect the instruction and operands sampled at the previous rising clock edge, so latency is exactly one cycle.
- R3: The instruction is split into opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. Opcode 0 with funct 32 writes `rs_val_i + rt_val_i` (modulo 2^32) to register rd.
- R4: Opcode 0 with funct 36, 37 or 38 writes the bitwise AND, OR or XOR of `rs_val_i` and `rt_val_i` to rd.
- R5: Opcodes 12, 13 and 14 write the AND, OR or XOR of `rs_val_i` with the zero-extended immediate [15:0] to register rt. AND clears bits 31:16. OR and XOR pass bits 31:16 through unchanged.
- R6: Opcode 8 writes `rs_val_i` plus the sign-extended immediate [15:0], modulo 2^32, to rt.
- R7: Opcode 0 with funct 0 shifts `rt_val_i` left by shamt, and funct 2 shifts it right by shamt. Both fill vacated bits with zeros and write to rd.
- R8: Opcode 0 with funct 3 shifts `rt_val_i` right by shamt and fills vacated bits with copies of its bit 31.
- R9: Opcode 15 writes the immediate into bits 31:16 of rt and zeros into bits 15:0.
- R10: A recognised instruction whose destination index is 0 produces `wr_en_o` = 0. Whenever `wr_en_o` is 0, `result_o` and `wr_idx_o` are 0.
- R11: Any other opcode, and opcode 0 with any other funct, produces `wr_en_o` = 0 with zero result and index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named by rs |
| rt_val_i | input | 32 | Value of the register named by rt |
| result_o | output | 32 | Registered result |
| wr_idx_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered write strobe |

## Verification
The bench drives sign-sensitive shifts with bit 31 both set and clear, and with amounts 0 and 31. A shifter that mixes up the fill source would return ones after a logical shift or zeros after an arithmetic one. It feeds negative immediates through both the add and the logical immediates. Swapping zero extension and sign extension there changes the upper half of the result. It also aims writes at register 0 and sends opcodes and function codes that lie next to legal ones. A stage that ignores the register-0 rule, or that decodes only part of a field, would raise the write strobe. Last, it chains a left shift by 16 into a right shift by 24 to pull byte 1 into the low byte, which checks that the shift amount field is taken from the right bit positions.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    // Instruction field positions (fixed by the encoding)
    localparam int INSN_W   = 32;
    localparam int OPC_LSB  = 26;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam int RD_LSB   = 11;
    localparam int SH_LSB   = 6;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 6;
    localparam int REG_AW   = 5;
    localparam int SH_W     = 5;
    localparam int IMM_W    = 16;

    // Major opcodes
    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

    // Function codes for the register form
    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL = 6'd2;
    localparam logic [FN_W-1:0] FN_SRA = 6'd3;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR = 6'd38;

    typedef enum logic [3:0] {
        K_NONE,
        K_AND,
        K_OR,
        K_XOR,
        K_ADD,
        K_SLL,
        K_SRL,
        K_SRA,
        K_LUI
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic                src_imm;    // second operand is the immediate
        logic                imm_signed; // sign-extend the immediate
        logic [REG_AW-1:0]   dst;
        logic                legal;
    } dec_t;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
    import lsx_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output dec_t              dec_o
);

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic [REG_AW-1:0] rt_f;
    logic [REG_AW-1:0] rd_f;

    assign opc  = instr_i[OPC_LSB +: OPC_W];
    assign fn   = instr_i[0 +: FN_W];
    assign rt_f = instr_i[RT_LSB +: REG_AW];
    assign rd_f = instr_i[RD_LSB +: REG_AW];

    always_comb begin
        dec_o            = '0;
        dec_o.kind       = K_NONE;
        if (opc == OPC_REG) begin
            dec_o.dst   = rd_f;
            dec_o.legal = 1'b1;
            unique case (fn)
                FN_SLL:  dec_o.kind = K_SLL;
                FN_SRL:  dec_o.kind = K_SRL;
                FN_SRA:  dec_o.kind = K_SRA;
                FN_ADD:  dec_o.kind = K_ADD;
                FN_AND:  dec_o.kind = K_AND;
                FN_OR:   dec_o.kind = K_OR;
                FN_XOR:  dec_o.kind = K_XOR;
                default: dec_o.legal = 1'b0;
            endcase
        end else begin
            dec_o.dst     = rt_f;
            dec_o.src_imm = 1'b1;
            dec_o.legal   = 1'b1;
            unique case (opc)
                OPC_ADDI: begin
                    dec_o.kind       = K_ADD;
                    dec_o.imm_signed = 1'b1;
                end
                OPC_ANDI: dec_o.kind = K_AND;
                OPC_ORI:  dec_o.kind = K_OR;
                OPC_XORI: dec_o.kind = K_XOR;
                OPC_LUI:  dec_o.kind = K_LUI;
                default:  dec_o.legal = 1'b0;
            endcase
        end
        if (!dec_o.legal) begin
            dec_o = '0;
            dec_o.kind = K_NONE;
        end
    end

endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              left_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int STAGES = AMT_W;

    logic [DATA_W-1:0]             rev_in;
    logic [DATA_W-1:0]             rev_out;
    logic [STAGES:0][DATA_W-1:0]   stg;
    logic                          fill;

    // Left shifts reuse the right-shift network on bit-reversed data
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = val_i[DATA_W-1-i];
        assign rev_out[i] = stg[STAGES][DATA_W-1-i];
    end

    assign fill   = arith_i & ~left_i & val_i[DATA_W-1];
    assign stg[0] = left_i ? rev_in : val_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{DIST{fill}}, stg[k][DATA_W-1:DIST]} : stg[k];
    end

    assign res_o = left_i ? rev_out : stg[STAGES];

endmodule

// File: rtl/lsx_alu.sv
module lsx_alu
    import lsx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_kind_e          kind_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        unique case (kind_i)
            K_AND:   res_o = a_i & b_i;
            K_OR:    res_o = a_i | b_i;
            K_XOR:   res_o = a_i ^ b_i;
            K_ADD:   res_o = a_i + b_i;
            K_LUI:   res_o = b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/bitop_exec_stage.sv
module bitop_exec_stage
    import lsx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INSN_W-1:0]    instr_i,
    input  logic [DATA_W-1:0]    rs_val_i,
    input  logic [DATA_W-1:0]    rt_val_i,
    output logic [DATA_W-1:0]    result_o,
    output logic [REG_AW-1:0]    wr_idx_o,
    output logic                 wr_en_o
);

    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [REG_AW-1:0] idx;
        logic              we;
    } stage_t;

    dec_t              dec;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] sh_res;
    logic              is_shift;
    stage_t            out_d, out_q;

    lsx_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign imm     = instr_i[0 +: IMM_W];
    assign imm_ext = dec.imm_signed ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
    assign opnd_b  = (dec.kind == K_LUI) ? {imm, {EXT_W{1'b0}}}
                   : (dec.src_imm ? imm_ext : rt_val_i);

    lsx_alu #(.DATA_W(DATA_W)) u_alu (
        .kind_i (dec.kind),
        .a_i    (rs_val_i),
        .b_i    (opnd_b),
        .res_o  (alu_res)
    );

    lsx_shifter #(.DATA_W(DATA_W), .AMT_W(SH_W)) u_shift (
        .val_i   (rt_val_i),
        .amt_i   (instr_i[SH_LSB +: SH_W]),
        .left_i  (dec.kind == K_SLL),
        .arith_i (dec.kind == K_SRA),
        .res_o   (sh_res)
    );

    assign is_shift = (dec.kind == K_SLL) || (dec.kind == K_SRL) || (dec.kind == K_SRA);

    always_comb begin
        out_d = '0;
        if (dec.legal && (dec.dst != '0)) begin
            out_d.we  = 1'b1;
            out_d.idx = dec.dst;
            out_d.res = is_shift ? sh_res : alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign wr_idx_o = out_q.idx;
    assign wr_en_o  = out_q.we;

    // R10: register 0 is never the target of a write
    p_no_zero_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o != '0));

    // R10/R11: idle outputs are cleared
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> (result_o == '0 && wr_idx_o == '0));

    // R9: load-upper leaves the low half clear
    p_lui_layout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_LUI) |->
        (result_o[IMM_W-1:0] == '0 && result_o[DATA_W-1:IMM_W] == $past(instr_i[IMM_W-1:0])));

    // R5: AND with a zero-extended immediate clears the upper half
    p_andi_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_ANDI) |->
        (result_o[DATA_W-1:IMM_W] == '0));

    // R8: arithmetic right shift keeps the sign
    p_sra_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_REG
                 && $past(instr_i[FN_W-1:0]) == FN_SRA) |->
        (result_o[DATA_W-1] == $past(rt_val_i[DATA_W-1])));

    // R3: register-form results go to rd
    p_rform_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_REG) |->
        (wr_idx_o == $past(instr_i[RD_LSB +: REG_AW])));

endmodule

// File: tb/bitop_exec_stage_tb_top.sv
module bitop_exec_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic [31:0] rs_v;
    logic [31:0] rt_v;
    logic [31:0] result;
    logic [4:0]  wr_idx;
    logic        wr_en;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bitop_exec_stage dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_i  (instr),
        .rs_val_i (rs_v),
        .rt_val_i (rt_v),
        .result_o (result),
        .wr_idx_o (wr_idx),
        .wr_en_o  (wr_en)
    );

    function automatic logic [31:0] rform(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Behavioural reference built from the requirements
    task automatic ref_eval(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                            output logic [31:0] r, output logic w, output logic [4:0] ix);
        logic [5:0]  op  = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  sh  = ins[10:6];
        logic [15:0] imm = ins[15:0];
        logic        ok  = 1'b1;
        r = 32'h0;
        if (op == 6'd0) begin
            ix = ins[15:11];
            case (fn)
                6'd0:    r = b << sh;
                6'd2:    r = b >> sh;
                6'd3:    r = 32'($signed(b) >>> sh);
                6'd32:   r = a + b;
                6'd36:   r = a & b;
                6'd37:   r = a | b;
                6'd38:   r = a ^ b;
                default: ok = 1'b0;
            endcase
        end else begin
            ix = ins[20:16];
            case (op)
                6'd8:    r = a + {{16{imm[15]}}, imm};
                6'd12:   r = a & {16'h0, imm};
                6'd13:   r = a | {16'h0, imm};
                6'd14:   r = a ^ {16'h0, imm};
                6'd15:   r = {imm, 16'h0};
                default: ok = 1'b0;
            endcase
        end
        if (!ok || ix == 5'd0) begin
            r = 32'h0; w = 1'b0; ix = 5'd0;
        end else begin
            w = 1'b1;
        end
    endtask

    task automatic compare(input string req, input logic [31:0] er, input logic ew,
                           input logic [4:0] ei);
        n_vec++;
        if (result !== er || wr_en !== ew || wr_idx !== ei) begin
            n_fail++;
            $display("FAIL %s: got res=%08h we=%0b idx=%0d, expected res=%08h we=%0b idx=%0d",
                     req, result, wr_en, wr_idx, er, ew, ei);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register)
    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = ins; rs_v = a; rt_v = b;
        @(negedge clk);
    endtask

    task automatic run_ref(input string req, input logic [31:0] ins,
                           input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er; logic ew; logic [4:0] ei;
        apply(ins, a, b);
        ref_eval(ins, a, b, er, ew, ei);
        compare(req, er, ew, ei);
    endtask

    task automatic run_lit(input string req, input logic [31:0] ins, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] er, input logic ew,
                           input logic [4:0] ei);
        apply(ins, a, b);
        compare(req, er, ew, ei);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        instr = iform(6'd13, 5'd1, 5'd2, 16'hFFFF);
        rs_v = 32'hDEAD_BEEF; rt_v = 32'h1;
        repeat (3) @(negedge clk);
        compare("R1 during reset", 32'h0, 1'b0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        instr = 32'h0; rs_v = 32'h0; rt_v = 32'h0;
        compare("R1 after release", 32'h0, 1'b0, 5'd0);
    endtask

    task automatic t_latency();
        // R2: two back-to-back vectors, each visible one cycle later
        @(negedge clk);
        instr = rform(5'd1, 5'd2, 5'd3, 5'd0, 6'd32); rs_v = 32'd5; rt_v = 32'd7;
        @(negedge clk);
        compare("R2 first", 32'd12, 1'b1, 5'd3);
        instr = rform(5'd1, 5'd2, 5'd4, 5'd0, 6'd38); rs_v = 32'hF0F0; rt_v = 32'h0FF0;
        @(negedge clk);
        compare("R2 second", 32'hFF00, 1'b1, 5'd4);
    endtask

    task automatic t_add();
        run_lit("R3 add", rform(5'd17, 5'd18, 5'd8, 5'd0, 6'd32), 32'd100, 32'd23,
                32'd123, 1'b1, 5'd8);
        run_lit("R3 add wrap", rform(5'd1, 5'd2, 5'd31, 5'd0, 6'd32), 32'hFFFF_FFFF, 32'd1,
                32'h0, 1'b1, 5'd31);
    endtask

    task automatic t_logic_reg();
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a = 32'h1234_5678 * (i + 3) ^ 32'hA5A5_0F0F;
            logic [31:0] b = 32'h9E37_79B9 * (i + 1);
            run_ref("R4 and", rform(5'd3, 5'd4, 5'd9,  5'd0, 6'd36), a, b);
            run_ref("R4 or",  rform(5'd3, 5'd4, 5'd10, 5'd0, 6'd37), a, b);
            run_ref("R4 xor", rform(5'd3, 5'd4, 5'd11, 5'd0, 6'd38), a, b);
        end
    endtask

    task automatic t_logic_imm();
        run_lit("R5 ori", iform(6'd13, 5'd8, 5'd9, 16'hFFFF), 32'h1234_5678, 32'h0,
                32'h1234_FFFF, 1'b1, 5'd9);
        run_lit("R5 andi", iform(6'd12, 5'd8, 5'd9, 16'h0FFF), 32'hB6A4_3D9A, 32'h0,
                32'h0000_0D9A, 1'b1, 5'd9);
        run_lit("R5 xori high bit", iform(6'd14, 5'd8, 5'd7, 16'h8001), 32'hFFFF_0000,
                32'h0, 32'hFFFF_8001, 1'b1, 5'd7);
        run_lit("R5 andi negative imm", iform(6'd12, 5'd8, 5'd7, 16'hFF00), 32'hFFFF_FFFF,
                32'h0, 32'h0000_FF00, 1'b1, 5'd7);
    endtask

    task automatic t_addi();
        run_lit("R6 addi neg", iform(6'd8, 5'd29, 5'd29, 16'hFFFC), 32'h0000_0010, 32'h0,
                32'h0000_000C, 1'b1, 5'd29);
        run_lit("R6 addi pos", iform(6'd8, 5'd29, 5'd29, 16'd4), 32'h7FFF_FFFE, 32'h0,
                32'h8000_0002, 1'b1, 5'd29);
    endtask

    task automatic t_shift_logic();
        run_lit("R7 srl 8", rform(5'd0, 5'd5, 5'd6, 5'd8, 6'd2), 32'h0, 32'h1234_5678,
                32'h0012_3456, 1'b1, 5'd6);
        run_lit("R7 sll 8", rform(5'd0, 5'd5, 5'd6, 5'd8, 6'd0), 32'h0, 32'h1234_5678,
                32'h3456_7800, 1'b1, 5'd6);
        run_lit("R7 srl zero fill", rform(5'd0, 5'd5, 5'd6, 5'd31, 6'd2), 32'h0,
                32'h8000_0000, 32'h1, 1'b1, 5'd6);
        run_lit("R7 sll by 0", rform(5'd0, 5'd5, 5'd6, 5'd0, 6'd0), 32'h0, 32'hCAFE_F00D,
                32'hCAFE_F00D, 1'b1, 5'd6);
        for (int s = 0; s < 32; s += 5) begin
            run_ref("R7 sll sweep", rform(5'd0, 5'd5, 5'd12, 5'(s), 6'd0), 32'h0, 32'h9234_5679);
            run_ref("R7 srl sweep", rform(5'd0, 5'd5, 5'd13, 5'(s), 6'd2), 32'h0, 32'h9234_5679);
        end
    endtask

    task automatic t_sra();
        run_lit("R8 sra neg", rform(5'd0, 5'd5, 5'd6, 5'd8, 6'd3), 32'h0, 32'h9234_5678,
                32'hFF92_3456, 1'b1, 5'd6);
        run_lit("R8 sra pos", rform(5'd0, 5'd5, 5'd6, 5'd8, 6'd3), 32'h0, 32'h1234_5678,
                32'h0012_3456, 1'b1, 5'd6);
        run_lit("R8 sra 31", rform(5'd0, 5'd5, 5'd6, 5'd31, 6'd3), 32'h0, 32'h8000_0000,
                32'hFFFF_FFFF, 1'b1, 5'd6);
        for (int s = 1; s < 32; s += 6)
            run_ref("R8 sra sweep", rform(5'd0, 5'd5, 5'd14, 5'(s), 6'd3), 32'h0, 32'hC00F_0FF1);
    endtask

    task automatic t_lui();
        run_lit("R9 lui", iform(6'd15, 5'd0, 5'd1, 16'hCDEF), 32'hFFFF_FFFF, 32'h0,
                32'hCDEF_0000, 1'b1, 5'd1);
    endtask

    task automatic t_byte_extract();
        // R7: shift left 16 then right 24 leaves byte 1 in the low byte
        logic [31:0] mid;
        apply(rform(5'd0, 5'd8, 5'd8, 5'd16, 6'd0), 32'h0, 32'h1234_5678);
        compare("R7 extract step1", 32'h5678_0000, 1'b1, 5'd8);
        mid = result;
        apply(rform(5'd0, 5'd8, 5'd8, 5'd24, 6'd2), 32'h0, mid);
        compare("R7 extract step2", 32'h0000_0056, 1'b1, 5'd8);
    endtask

    task automatic t_zero_dest();
        run_lit("R10 add to r0", rform(5'd1, 5'd2, 5'd0, 5'd0, 6'd32), 32'd9, 32'd9,
                32'h0, 1'b0, 5'd0);
        run_lit("R10 ori to r0", iform(6'd13, 5'd1, 5'd0, 16'h1234), 32'hFFFF_0000, 32'h0,
                32'h0, 1'b0, 5'd0);
    endtask

    task automatic t_illegal();
        run_lit("R11 funct 1", rform(5'd1, 5'd2, 5'd3, 5'd4, 6'd1), 32'h1, 32'h2,
                32'h0, 1'b0, 5'd0);
        run_lit("R11 funct 39", rform(5'd1, 5'd2, 5'd3, 5'd0, 6'd39), 32'h1, 32'h2,
                32'h0, 1'b0, 5'd0);
        run_lit("R11 opcode 9", iform(6'd9, 5'd1, 5'd3, 16'h0001), 32'h1, 32'h2,
                32'h0, 1'b0, 5'd0);
        run_lit("R11 opcode 47", iform(6'd47, 5'd1, 5'd3, 16'h0001), 32'h1, 32'h2,
                32'h0, 1'b0, 5'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_add();
        t_logic_reg();
        t_logic_imm();
        t_addi();
        t_shift_logic();
        t_sra();
        t_lui();
        t_byte_extract();
        t_zero_dest();
        t_illegal();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule